// File: doc/BRIEF.md
# Serial-Access Word Array

This block models a small read-only user memory of 512 sixteen-bit words. The memory is reached through two serial registers, and each has its own slow serial clock. The address register is 9 bits wide. On each of its clock edges it either takes in one serial bit or steps forward by one. The data register is 16 bits wide. On each of its clock edges it either shifts one bit through, or it copies the word at the current address in a single step. The most significant bit of the data register is always visible on the serial output.

Both serial clocks are slow compared with the system clock. Each one is brought into the system clock domain through a two-flop synchroniser, and its rising edge is turned into a one-cycle strobe there. The mode and serial data pins are sampled in the cycle of that strobe. Every array word is computed from two parameters, so the contents are fixed when the block is built. Reset clears both registers and leaves the array as it is.

A host uses the block in three steps. It shifts in an address, with the most significant bit first. It then pulses the data clock with the data mode low, which loads the word. Finally it reads the word out by shifting. Sequential words are read by stepping the address.

Top module: `sflash_word_array`

## Requirements
- R1: While rst_n is low, and right after it rises, the address register and the data register are zero, so data_sout is 0. Reset does not alter any array word.
- R2: At a detected address-clock rising edge with addr_mode = 1, addr_sin enters bit 0 and the other bits move up by one place. The old bit 8 is lost. So the last 9 bits sent, most significant bit first, form the address.
- R3: At a detected address-clock rising edge with addr_mode = 0, the address register increases by 1.
- R4: Stepping from address 511 gives address 0.
- R5: At a detected data-clock rising edge with data_mode = 1, data_sin enters bit 0 and the other bits move up by one place.
- R6: At a detected data-clock rising edge with data_mode = 0, the data register takes the array word at the current address.
- R7: data_sout always equals bit 15 of the data register. After a load, the word therefore comes out from bit 15 down to bit 0, and one data-clock shift moves to each next bit.
- R8: Each rising edge of a serial clock acts exactly once, however long the clock then stays high. Each high phase and each low phase must last at least 4 system clock cycles.
- R9: If address and data clock edges are detected in the same cycle, a data load uses the address as it was before that cycle's address update.
- R10: The word at address a is (a * INIT_MULT + INIT_OFFSET) mod 65536. The defaults are INIT_MULT = 40503 and INIT_OFFSET = 23100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sclk | input | 1 | Address serial clock (asynchronous) |
| addr_mode | input | 1 | 1 = shift address, 0 = step address |
| addr_sin | input | 1 | Address serial input |
| data_sclk | input | 1 | Data serial clock (asynchronous) |
| data_mode | input | 1 | 1 = shift data, 0 = load word |
| data_sin | input | 1 | Data serial input |
| data_sout | output | 1 | Data serial output (bit 15 of data register) |

## Verification
Two actions can fall in the same system cycle: an address step and a data load. This happens when the two serial clocks rise together, so both strobes are detected in one cycle. The bench provokes this by raising both clocks at the same instant, with the address mode set to step and the data mode set to load. The loaded word must belong to the old address. The next load alone must return the word at the following address, which shows that the step also took effect.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

  // Action taken by a serial register at a system clock cycle
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_ALT   = 2'd2   // step address or parallel load
  } reg_act_e;

  function automatic reg_act_e pick_act(input logic strobe, input logic mode);
    if (!strobe)   return ACT_HOLD;
    else if (mode) return ACT_SHIFT;
    else           return ACT_ALT;
  endfunction

  // Array word content as a function of its address
  function automatic logic [31:0] init_word(input logic [31:0] addr,
                                            input logic [31:0] mult,
                                            input logic [31:0] offs);
    return addr * mult + offs;
  endfunction

endpackage

// File: rtl/sfa_edge_sync.sv
module sfa_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sclk;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], sclk};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sfa_addr_reg.sv
module sfa_addr_reg
  import sfa_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              mode,
  input  logic              sin,
  output logic [ADDR_W-1:0] addr_q
);
  reg_act_e act;
  assign act = pick_act(strobe, mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      case (act)
        ACT_SHIFT: addr_q <= {addr_q[ADDR_W-2:0], sin};
        ACT_ALT:   addr_q <= addr_q + 1'b1;
        default:   addr_q <= addr_q;
      endcase
    end
  end
endmodule

// File: rtl/sfa_data_reg.sv
module sfa_data_reg
  import sfa_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              mode,
  input  logic              sin,
  input  logic [DATA_W-1:0] load_word,
  output logic [DATA_W-1:0] data_q
);
  reg_act_e act;
  assign act = pick_act(strobe, mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      case (act)
        ACT_SHIFT: data_q <= {data_q[DATA_W-2:0], sin};
        ACT_ALT:   data_q <= load_word;
        default:   data_q <= data_q;
      endcase
    end
  end
endmodule

// File: rtl/sfa_word_rom.sv
module sfa_word_rom
  import sfa_pkg::*;
#(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 16,
  parameter logic [31:0] INIT_MULT   = 32'd40503,
  parameter logic [31:0] INIT_OFFSET = 32'd23100
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    localparam logic [31:0] FULL = init_word(gi, INIT_MULT, INIT_OFFSET);
    assign words[gi] = FULL[DATA_W-1:0];
  end

  assign rd_word = words[rd_addr];
endmodule

// File: rtl/sflash_word_array.sv
module sflash_word_array #(
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] INIT_MULT   = 32'd40503,
  parameter logic [31:0] INIT_OFFSET = 32'd23100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_sclk,
  input  logic addr_mode,
  input  logic addr_sin,
  input  logic data_sclk,
  input  logic data_mode,
  input  logic data_sin,
  output logic data_sout
);
  // Named internal events, observed by the bound checker
  logic              a_rise;
  logic              d_rise;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rom_word;

  sfa_edge_sync #(.STAGES(SYNC_STAGES)) u_async (
    .clk (clk), .rst_n (rst_n), .sclk (addr_sclk), .rise (a_rise)
  );

  sfa_edge_sync #(.STAGES(SYNC_STAGES)) u_dsync (
    .clk (clk), .rst_n (rst_n), .sclk (data_sclk), .rise (d_rise)
  );

  sfa_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk (clk), .rst_n (rst_n), .strobe (a_rise),
    .mode (addr_mode), .sin (addr_sin), .addr_q (addr_q)
  );

  sfa_word_rom #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .INIT_MULT (INIT_MULT), .INIT_OFFSET (INIT_OFFSET)
  ) u_rom (
    .rd_addr (addr_q), .rd_word (rom_word)
  );

  // Load sees the registered address, i.e. the value before a same-cycle step
  sfa_data_reg #(.DATA_W(DATA_W)) u_dreg (
    .clk (clk), .rst_n (rst_n), .strobe (d_rise),
    .mode (data_mode), .sin (data_sin),
    .load_word (rom_word), .data_q (data_q)
  );

  assign data_sout = data_q[DATA_W-1];
endmodule

// File: rtl/sfa_checker.sv
module sfa_checker #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_mode,
  input logic              addr_sin,
  input logic              data_mode,
  input logic              data_sin,
  input logic              a_rise,
  input logic              d_rise,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] data_q,
  input logic [DATA_W-1:0] rom_word
);
  AST_ADDR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && addr_mode) |=> addr_q == {$past(addr_q[ADDR_W-2:0]), $past(addr_sin)}); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && !addr_mode) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1)); // R3

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && !addr_mode && (&addr_q)) |=> addr_q == '0); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rise |=> $stable(addr_q)); // R8

  AST_DATA_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rise && data_mode) |=> data_q == {$past(data_q[DATA_W-2:0]), $past(data_sin)}); // R5

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rise && !data_mode) |=> data_q == $past(rom_word)); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !d_rise |=> $stable(data_q)); // R8

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise || d_rise) |=> !($past(a_rise) && a_rise) && !($past(d_rise) && d_rise)); // R8
endmodule

bind sflash_word_array sfa_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk (clk), .rst_n (rst_n),
  .addr_mode (addr_mode), .addr_sin (addr_sin),
  .data_mode (data_mode), .data_sin (data_sin),
  .a_rise (a_rise), .d_rise (d_rise),
  .addr_q (addr_q), .data_q (data_q), .rom_word (rom_word)
);

// File: tb/sflash_word_array_tb_top.sv
`timescale 1ns/1ps
module sflash_word_array_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sclk = 1'b0, addr_mode = 1'b0, addr_sin = 1'b0;
  logic data_sclk = 1'b0, data_mode = 1'b0, data_sin = 1'b0;
  logic data_sout;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  sflash_word_array dut_i (
    .clk (clk), .rst_n (rst_n),
    .addr_sclk (addr_sclk), .addr_mode (addr_mode), .addr_sin (addr_sin),
    .data_sclk (data_sclk), .data_mode (data_mode), .data_sin (data_sin),
    .data_sout (data_sout)
  );

  // Scoreboard queues: expected bit and requirement number
  bit exp_q[$];
  int req_q[$];
  event smp_ev;

  // Reference content (R10), written independently of the RTL
  function automatic logic [15:0] ref_word(input int a);
    int unsigned v;
    v = (a % 512) * 40503 + 23100;
    return v[15:0];
  endfunction

  // Monitor: pops one expected item per sample event
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() > 0) begin
        bit e; int r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        vectors++;
        if (data_sout !== e) begin
          misses++;
          $display("FAIL R%0d: data_sout=%0b expected %0b at %0t", r, data_sout, e, $time);
        end
      end
    end
  end

  task automatic expect_bit(input bit e, input int r);
    exp_q.push_back(e);
    req_q.push_back(r);
    -> smp_ev;
    @(negedge clk);
  endtask

  // One serial clock period on either or both serial clocks
  task automatic pulse(input bit do_a, input bit a_m, input bit a_b,
                       input bit do_d, input bit d_m, input bit d_b,
                       input int high_len);
    @(negedge clk);
    addr_mode = a_m; addr_sin = a_b;
    data_mode = d_m; data_sin = d_b;
    repeat (2) @(negedge clk);
    if (do_a) addr_sclk = 1'b1;
    if (do_d) data_sclk = 1'b1;
    repeat (high_len) @(negedge clk);
    addr_sclk = 1'b0;
    data_sclk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_addr(input int v, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) pulse(1, 1, v[i], 0, 1, 0, 5); // R2
  endtask

  task automatic step_addr();
    pulse(1, 0, 0, 0, 1, 0, 5); // R3
  endtask

  task automatic load_word();
    pulse(0, 1, 0, 1, 0, 0, 5); // R6
  endtask

  // Read out the 16 bits now in the data register, checking each (R7)
  task automatic read_out(input logic [15:0] w, input int r);
    expect_bit(w[15], r);
    for (int i = 14; i >= 0; i--) begin
      pulse(0, 1, 0, 1, 1, 0, 5);
      expect_bit(w[i], 7);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    do_reset();

    // R1: registers cleared, output low, data register all zero
    read_out(16'h0000, 1);

    // R10 / R6: word at address 0 after reset
    load_word();
    read_out(ref_word(0), 10);

    // R2: address shifted in MSB first
    send_addr(165, 9);
    load_word();
    read_out(ref_word(165), 2);

    // R3: single and repeated steps
    step_addr();
    load_word();
    read_out(ref_word(166), 3);
    step_addr();
    step_addr();
    load_word();
    read_out(ref_word(168), 3);

    // R2: ten bits sent, oldest one falls off
    send_addr(10'h203, 10);
    load_word();
    read_out(ref_word(3), 2);

    // R4: wrap from 511 to 0
    send_addr(510, 9);
    load_word();
    read_out(ref_word(510), 4);
    step_addr();
    load_word();
    read_out(ref_word(511), 4);
    step_addr();
    load_word();
    read_out(ref_word(0), 4);

    // R5: shift a pattern in, first bit sent reaches the MSB
    pat = 16'hC3A5;
    for (int i = 15; i >= 0; i--) pulse(0, 1, 0, 1, 1, pat[i], 5);
    read_out(pat, 5);

    // R8: a long high phase acts only once
    send_addr(77, 9);
    load_word();
    expect_bit(ref_word(77)[15], 8);
    pulse(0, 1, 0, 1, 1, 0, 30);
    expect_bit(ref_word(77)[14], 8);
    pulse(0, 1, 0, 1, 1, 0, 5);
    expect_bit(ref_word(77)[13], 8);

    // R9: step and load detected together, load sees the old address
    send_addr(40, 9);
    pulse(1, 0, 0, 1, 0, 0, 5);
    read_out(ref_word(40), 9);
    load_word();
    read_out(ref_word(41), 9);

    // R1: mid-run reset clears address and data, array unchanged
    send_addr(300, 9);
    load_word();
    do_reset();
    expect_bit(1'b0, 1);
    load_word();
    read_out(ref_word(0), 1);
    send_addr(300, 9);
    load_word();
    read_out(ref_word(300), 1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule